// File: doc/BRIEF.md
# Level-Sensitive Interrupt Presenter

This block is the interrupt controller for a single processor. It holds both the source side and the presentation side in one unit. It watches a parameterised set of level-sensitive hardware lines. Each line has a source number that is fixed by its index plus a constant base, so software cannot reassign it. Every hardware source carries one hardwired priority, where a numerically smaller value is more favoured. The controller raises a single registered request to the core while some line is high and that priority beats the processor's current priority.

Software reaches the block through a Wishbone slave port that decodes an 8-bit byte address. The port has two word registers:

- **Priority register, offset 0x00.** It holds the current processor priority.
- **Accept/EOI register, offset 0x04.** A read accepts the presented interrupt. It returns the previous current priority together with the source number, and it raises the current priority to the hardware level, which masks further requests. A write ends the interrupt by restoring the current priority from the top byte.

Line 0 is an ordinary source, for example a serial port, and is delivered like any other line.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset the current priority is 0, `ext_irq_req` is low and `wb_ack` is low. Priority 0 masks every source.
- R2: The presented source number is `SRC_BASE` plus the index of the lowest-numbered high line. Line 0 yields `SRC_BASE` itself. When nothing is presentable the source number is 0.
- R3: `ext_irq_req` is high exactly one clock after a cycle in which at least one line was high and `HW_PRIO` was strictly below the current priority. At equality the request stays masked.
- R4: A write to offset 0x00 loads the current priority from data bits 7:0. A read of offset 0x00 returns the current priority in bits 7:0 with all other bits zero.
- R5: A read of offset 0x04 returns the old current priority in bits 31:24 and the source number in bits 23:0. If something was presentable, the read sets the current priority to `HW_PRIO`, so the request drops on the following clock. If nothing was presentable, the current priority is unchanged.
- R6: A write to offset 0x04 loads the current priority from data bits 31:24. The request then re-asserts one clock later if a line is still high.
- R7: Every cycle with `wb_cyc` and `wb_stb` high is acknowledged on the next cycle. `wb_ack` is never high otherwise, and `wb_stall` is always low.
- R8: Reads of any offset other than 0x00 and 0x04 return zero. Writes to those offsets change neither the current priority nor the request.
- R9: Lines are not latched. Once every line falls, the request drops one clock later and an accept read returns source 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_cyc | input | 1 | Bus cycle valid |
| wb_stb | input | 1 | Strobe for this transfer |
| wb_we | input | 1 | Write enable |
| wb_adr | input | 8 | Byte address, low 8 bits |
| wb_dat_w | input | 32 | Write data |
| wb_dat_r | output | 32 | Read data, registered |
| wb_ack | output | 1 | Acknowledge, one cycle after the strobe |
| wb_stall | output | 1 | Always low |
| irq_lines | input | NUM_LINES | Level-sensitive interrupt lines |
| ext_irq_req | output | 1 | External interrupt request to the core |

## Verification
The bench uses the defaults: `NUM_LINES` = 16, `HW_PRIO` = 8 and `SRC_BASE` = 16. With 16 lines, both the lowest line (source 16) and the highest line (source 31) can be driven, alone and together with other lines. Because `HW_PRIO` is small and nonzero, the bench can set the current priority to exactly 8 and to 9, which places the strict-comparison boundary on either side. It can also program 0xFF to unmask everything, and it can observe the masking from the reset value 0.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;

    localparam int PRI_W = 8;
    localparam int SRC_W = 24;
    localparam int DAT_W = 32;

    localparam logic [5:0] OFS_PRI = 6'd0;
    localparam logic [5:0] OFS_ACC = 6'd1;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_PRI_WR,
        CMD_ACCEPT,
        CMD_EOI
    } pri_cmd_kind_e;

    typedef struct packed {
        pri_cmd_kind_e    kind;
        logic [PRI_W-1:0] pri;
    } pri_cmd_t;

    function automatic logic pri_beats(input logic [PRI_W-1:0] hw,
                                       input logic [PRI_W-1:0] cur);
        return hw < cur;
    endfunction

endpackage

// File: rtl/lvl_irq_encoder.sv
module lvl_irq_encoder
    import lvl_irq_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int SRC_BASE  = 16
) (
    input  logic [NUM_LINES-1:0] lines,
    output logic                 hit,
    output logic [SRC_W-1:0]     src_num
);

    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

    logic [IDX_W-1:0] low_idx;

    always_comb begin
        hit     = 1'b0;
        low_idx = '0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (lines[i]) begin
                hit     = 1'b1;
                low_idx = IDX_W'(i);
            end
        end
    end

    assign src_num = SRC_W'(SRC_BASE) + SRC_W'(low_idx);

endmodule

// File: rtl/lvl_irq_pri_state.sv
module lvl_irq_pri_state
    import lvl_irq_pkg::*;
#(
    parameter logic [PRI_W-1:0] HW_PRIO = 8'd8
) (
    input  logic             clk,
    input  logic             rst,
    input  pri_cmd_t         cmd,
    input  logic             hit,
    output logic [PRI_W-1:0] cur_pri,
    output logic             presentable,
    output logic             req
);

    assign presentable = hit && pri_beats(HW_PRIO, cur_pri);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_pri <= '0;
            req     <= 1'b0;
        end else begin
            req <= presentable;
            case (cmd.kind)
                CMD_PRI_WR: cur_pri <= cmd.pri;
                CMD_EOI:    cur_pri <= cmd.pri;
                CMD_ACCEPT: if (presentable) cur_pri <= HW_PRIO;
                default:    ;
            endcase
        end
    end

    // R3: a request is only raised after a cycle with a high line and an unmasking priority
    a_r3_req_cause: assert property (@(posedge clk) disable iff (rst)
        req |-> ($past(hit) && ($past(cur_pri) > HW_PRIO)));

    // R5: an accept of a presentable source raises the priority to the hardware level
    a_r5_accept_raises: assert property (@(posedge clk) disable iff (rst)
        (cmd.kind == CMD_ACCEPT && hit && cur_pri > HW_PRIO) |=> (cur_pri == HW_PRIO));

    // R5: an accept with nothing presentable leaves the priority alone
    a_r5_accept_idle: assert property (@(posedge clk) disable iff (rst)
        (cmd.kind == CMD_ACCEPT && !(hit && cur_pri > HW_PRIO)) |=> $stable(cur_pri));

    // R6: end-of-interrupt restores the supplied priority
    a_r6_eoi_restores: assert property (@(posedge clk) disable iff (rst)
        (cmd.kind == CMD_EOI) |=> (cur_pri == $past(cmd.pri)));

endmodule

// File: rtl/lvl_irq_bus.sv
module lvl_irq_bus
    import lvl_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cyc,
    input  logic             stb,
    input  logic             we,
    input  logic [7:0]       adr,
    input  logic [DAT_W-1:0] wdat,
    input  logic [PRI_W-1:0] cur_pri,
    input  logic             presentable,
    input  logic [SRC_W-1:0] src_num,
    output logic             ack,
    output logic [DAT_W-1:0] rdat,
    output pri_cmd_t         cmd
);

    logic             access;
    logic [5:0]       ofs;
    logic [DAT_W-1:0] rdat_next;

    assign access = cyc && stb;
    assign ofs    = adr[7:2];

    always_comb begin
        cmd.kind = CMD_NONE;
        cmd.pri  = '0;
        if (access) begin
            if (ofs == OFS_PRI && we) begin
                cmd.kind = CMD_PRI_WR;
                cmd.pri  = wdat[PRI_W-1:0];
            end else if (ofs == OFS_ACC) begin
                cmd.kind = we ? CMD_EOI : CMD_ACCEPT;
                cmd.pri  = wdat[DAT_W-1 -: PRI_W];
            end
        end
    end

    always_comb begin
        case (ofs)
            OFS_PRI: rdat_next = {{(DAT_W-PRI_W){1'b0}}, cur_pri};
            OFS_ACC: rdat_next = {cur_pri, presentable ? src_num : {SRC_W{1'b0}}};
            default: rdat_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ack  <= 1'b0;
            rdat <= '0;
        end else begin
            ack  <= access;
            rdat <= (access && !we) ? rdat_next : '0;
        end
    end

    // R7: each strobed cycle is acknowledged on the next cycle
    a_r7_ack_next: assert property (@(posedge clk) disable iff (rst)
        (cyc && stb) |=> ack);

    // R7: no acknowledge without a preceding strobe
    a_r7_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !(cyc && stb) |=> !ack);

    // R8: unmapped offsets read back as zero
    a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (cyc && stb && !we && adr[7:2] > 6'd1) |=> (rdat == '0));

endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
    import lvl_irq_pkg::*;
#(
    parameter int               NUM_LINES = 16,
    parameter logic [7:0]       HW_PRIO   = 8'd8,
    parameter int               SRC_BASE  = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wb_cyc,
    input  logic                 wb_stb,
    input  logic                 wb_we,
    input  logic [7:0]           wb_adr,
    input  logic [31:0]          wb_dat_w,
    output logic [31:0]          wb_dat_r,
    output logic                 wb_ack,
    output logic                 wb_stall,
    input  logic [NUM_LINES-1:0] irq_lines,
    output logic                 ext_irq_req
);

    logic             hit;
    logic [SRC_W-1:0] src_num;
    logic [PRI_W-1:0] cur_pri;
    logic             presentable;
    pri_cmd_t         cmd;

    assign wb_stall = 1'b0;

    lvl_irq_encoder #(
        .NUM_LINES (NUM_LINES),
        .SRC_BASE  (SRC_BASE)
    ) u_enc (
        .lines   (irq_lines),
        .hit     (hit),
        .src_num (src_num)
    );

    lvl_irq_pri_state #(
        .HW_PRIO (HW_PRIO)
    ) u_pri (
        .clk         (clk),
        .rst         (rst),
        .cmd         (cmd),
        .hit         (hit),
        .cur_pri     (cur_pri),
        .presentable (presentable),
        .req         (ext_irq_req)
    );

    lvl_irq_bus u_bus (
        .clk         (clk),
        .rst         (rst),
        .cyc         (wb_cyc),
        .stb         (wb_stb),
        .we          (wb_we),
        .adr         (wb_adr),
        .wdat        (wb_dat_w),
        .cur_pri     (cur_pri),
        .presentable (presentable),
        .src_num     (src_num),
        .ack         (wb_ack),
        .rdat        (wb_dat_r),
        .cmd         (cmd)
    );

    // R9: with every line low the request is down one clock later
    a_r9_level_drop: assert property (@(posedge clk) disable iff (rst)
        !(|irq_lines) |=> !ext_irq_req);

    // R2: an accepted source number is never below the base
    a_r2_src_floor: assert property (@(posedge clk) disable iff (rst)
        (wb_cyc && wb_stb && !wb_we && wb_adr[7:2] == OFS_ACC && (|irq_lines) && cur_pri > HW_PRIO)
        |=> (wb_dat_r[SRC_W-1:0] >= SRC_W'(SRC_BASE)));

endmodule

// File: tb/sim_lvl_irq_ctrl.sv
module sim_lvl_irq_ctrl;

    localparam int         NL   = 16;
    localparam logic [7:0] HWP  = 8'd8;
    localparam int         BASE = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wb_cyc = 1'b0, wb_stb = 1'b0, wb_we = 1'b0;
    logic [7:0]  wb_adr = '0;
    logic [31:0] wb_dat_w = '0;
    logic [31:0] wb_dat_r;
    logic        wb_ack, wb_stall, ext_irq_req;
    logic [NL-1:0] irq_lines = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    lvl_irq_ctrl #(.NUM_LINES(NL), .HW_PRIO(HWP), .SRC_BASE(BASE)) u0 (
        .clk(clk), .rst(rst), .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we),
        .wb_adr(wb_adr), .wb_dat_w(wb_dat_w), .wb_dat_r(wb_dat_r), .wb_ack(wb_ack),
        .wb_stall(wb_stall), .irq_lines(irq_lines), .ext_irq_req(ext_irq_req)
    );

    // vector: {lines, expected source}
    localparam logic [39:0] VEC [7] = '{
        {16'h0001, 24'd16},
        {16'h8000, 24'd31},
        {16'h0006, 24'd17},
        {16'hF000, 24'd28},
        {16'h0100, 24'd24},
        {16'hFFFF, 24'd16},
        {16'h0000, 24'd0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bus(input logic we, input logic [7:0] a, input logic [31:0] d,
                       output logic [31:0] r);
        wb_cyc = 1'b1; wb_stb = 1'b1; wb_we = we; wb_adr = a; wb_dat_w = d;
        tick();
        chk("R7 ack", {31'd0, wb_ack}, 32'd1);
        chk("R7 stall", {31'd0, wb_stall}, 32'd0);
        r = wb_dat_r;
        wb_cyc = 1'b0; wb_stb = 1'b0; wb_we = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        @(negedge clk);
        tick(); tick();
        chk("R1 req", {31'd0, ext_irq_req}, 32'd0);
        chk("R1 ack", {31'd0, wb_ack}, 32'd0);
        rst = 1'b0;
        tick();
        bus(1'b0, 8'h00, 32'h0, r);
        chk("R1 priority", r, 32'h0);
        irq_lines = 16'h0001;
        tick(); tick();
        chk("R1 masked at zero", {31'd0, ext_irq_req}, 32'd0);
        irq_lines = '0;

        // R4 priority register write/read
        bus(1'b1, 8'h00, 32'hABCD_12FF, r);
        bus(1'b0, 8'h00, 32'h0, r);
        chk("R4 readback", r, 32'h0000_00FF);
        tick();

        // table walk: R2, R3, R5, R6
        foreach (VEC[i]) begin
            logic [15:0] ln;
            logic [23:0] es;
            ln = VEC[i][39:24];
            es = VEC[i][23:0];
            irq_lines = ln;
            tick();
            chk("R3 req on line", {31'd0, ext_irq_req}, {31'd0, ln != 0});
            bus(1'b0, 8'h04, 32'h0, r);
            chk("R2/R5 accept data", r, {8'hFF, es});
            tick();
            chk("R5 req after accept", {31'd0, ext_irq_req}, 32'd0);
            bus(1'b0, 8'h00, 32'h0, r);
            chk("R5 priority after accept", r, (es != 0) ? 32'h8 : 32'hFF);
            bus(1'b1, 8'h04, 32'hFF00_0000, r);
            tick();
            chk("R6 req after eoi", {31'd0, ext_irq_req}, {31'd0, ln != 0});
        end

        // R3 boundary and registered timing
        irq_lines = '0;
        bus(1'b1, 8'h00, {24'd0, HWP}, r);
        irq_lines = 16'h0010;
        tick(); tick();
        chk("R3 equal priority masks", {31'd0, ext_irq_req}, 32'd0);
        bus(1'b1, 8'h00, {24'd0, HWP + 8'd1}, r);
        tick();
        chk("R3 one above unmasks", {31'd0, ext_irq_req}, 32'd1);
        irq_lines = '0;
        chk("R3 registered hold", {31'd0, ext_irq_req}, 32'd1);

        // R9 level drop
        tick();
        chk("R9 req drops", {31'd0, ext_irq_req}, 32'd0);
        bus(1'b0, 8'h04, 32'h0, r);
        chk("R9 accept none", r, {8'h09, 24'd0});
        irq_lines = 16'h0004;
        tick();
        irq_lines = '0;
        tick();
        chk("R9 short pulse gone", {31'd0, ext_irq_req}, 32'd0);

        // R8 unmapped offsets
        bus(1'b1, 8'h08, 32'h0000_0000, r);
        bus(1'b1, 8'h3C, 32'hFFFF_FFFF, r);
        bus(1'b0, 8'h00, 32'h0, r);
        chk("R8 priority untouched", r, 32'h0000_0009);
        bus(1'b0, 8'h08, 32'h0, r);
        chk("R8 read zero 0x08", r, 32'h0);
        bus(1'b0, 8'hFC, 32'h0, r);
        chk("R8 read zero 0xFC", r, 32'h0);
        irq_lines = 16'h0001;
        tick();
        chk("R8 req unaffected", {31'd0, ext_irq_req}, 32'd1);
        irq_lines = '0;

        // R7 idle ack
        tick();
        chk("R7 idle no ack", {31'd0, wb_ack}, 32'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule